// File: doc/BRIEF.md
# Cache Miss-Buffer Blocking Controller

This block keeps the blocking state for the request path of a non-blocking cache. It tracks how full two allocation queues are: the miss-status queue and the write/writeback buffer. It also takes a third blocking reason from outside, which reports that no free target slots remain. Each reason owns one bit of a blocking mask. The CPU-side port is stalled while any bit is set and released only when every bit is clear.

For every allocation the block accepts, it stamps a rising order number. A cacheable miss is aligned to the cache block boundary and sized to one block. Uncached reads and write-buffer entries pass through with their own address and size. An allocation can ask for the memory-side bus, and the request carries the queue's cause code. For each cause the block counts how many times that cause opened a stall, and how many cycles the stalls it closed lasted.

Control is a two-state machine. `ST_OPEN` means the port is unblocked and the mask is empty. `ST_STALLED` means at least one cause is active. The transitions are START (`ST_OPEN` to `ST_STALLED`, when the next mask is nonzero), HOLD (stay in `ST_STALLED` while the next mask is still nonzero) and RELEASE (`ST_STALLED` to `ST_OPEN`, when the next mask becomes zero). `ST_OPEN` stays where it is while the next mask is zero.

Top module: `cache_block_ctrl`

## Requirements
- R1: Reset clears the blocking mask, both queue occupancies, the order counter and every statistic counter. After reset, `cpu_blocked` is 0 and the first accepted allocation receives order 0.
- R2: Bit 0 of `block_mask` is cause 0 (miss queue full), bit 1 is cause 1 (write buffer full) and bit 2 is cause 2 (no free targets). `cpu_blocked` is 1 exactly when `block_mask` is nonzero.
- R3: An allocation request is accepted only when its queue is not full at the start of the cycle. A refused request has no effect and gives no grant. The accepted allocation that brings a queue's count to its depth raises that queue's `*_full` output and sets its mask bit, both on the next clock edge.
- R4: A mark-in-service on a non-empty queue removes one entry. It clears the queue's mask bit only when the queue was full before the operation and is not full after it. A mark-in-service on an empty queue is ignored.
- R5: `tgt_set` alone sets bit 2 and `tgt_clr` alone clears it. Both together have no effect. Setting a bit that is already set, or clearing one that is already clear, changes neither the counters nor `cpu_blocked`.
- R6: Each accepted allocation receives the next order number. When both queues accept in the same cycle, the miss gets N and the write buffer gets N+1.
- R7: An accepted cacheable miss is granted with its address rounded down to a multiple of BLK_BYTES and a size of BLK_BYTES. Uncached-read and write-buffer grants keep the requested address and size.
- R8: `bus_req` rises one cycle after an accepted allocation whose bus flag is set, unless `retry_wait` was high in the allocating cycle. `bus_cause` is 0 for the miss queue and 1 for the write buffer, and the miss queue wins when both ask.
- R9: When the mask goes from zero to nonzero, the event counter of the lowest-numbered cause being set increments by one. Setting causes while already blocked counts nothing.
- R10: When the mask becomes zero, the number of cycles `cpu_blocked` was high is added to the cycle counter of the cause whose clearing emptied it. If several causes clear together, the highest-numbered one is charged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ms_alloc | input | 1 | Allocate a miss-queue entry |
| ms_cacheable | input | 1 | 1: cacheable miss, 0: uncached read |
| ms_addr | input | ADDR_W | Miss request address |
| ms_size | input | SIZE_W | Miss request size in bytes |
| ms_bus | input | 1 | Miss allocation asks for the memory bus |
| ms_svc | input | 1 | Mark one miss entry in service |
| wb_alloc | input | 1 | Allocate a write-buffer entry |
| wb_addr | input | ADDR_W | Write address |
| wb_size | input | SIZE_W | Write size in bytes |
| wb_bus | input | 1 | Write allocation asks for the memory bus |
| wb_svc | input | 1 | Mark one write entry in service |
| tgt_set | input | 1 | Raise the no-free-targets cause |
| tgt_clr | input | 1 | Drop the no-free-targets cause |
| retry_wait | input | 1 | Memory port is waiting on a retry |
| cpu_blocked | output | 1 | CPU-side port stalled |
| block_mask | output | 3 | Active causes |
| ms_full | output | 1 | Miss queue at depth |
| wb_full | output | 1 | Write buffer at depth |
| ms_grant | output | 1 | Miss allocation accepted last cycle |
| ms_gnt_addr | output | ADDR_W | Granted miss address |
| ms_gnt_size | output | SIZE_W | Granted miss size |
| ms_gnt_order | output | ORD_W | Order number of miss grant |
| wb_grant | output | 1 | Write allocation accepted last cycle |
| wb_gnt_addr | output | ADDR_W | Granted write address |
| wb_gnt_size | output | SIZE_W | Granted write size |
| wb_gnt_order | output | ORD_W | Order number of write grant |
| bus_req | output | 1 | Memory-side bus request |
| bus_cause | output | 2 | Cause code of the bus request |
| stall_events | output | 3*STAT_W | Per-cause stall-opening counts, cause c at [c*STAT_W +: STAT_W] |
| stall_cycles | output | 3*STAT_W | Per-cause charged stall cycles, same layout |

## Verification
The bench targets several cases. An allocation that arrives while a queue is full must be refused; a design that takes it would overflow the count and never clear the bit. A mark-in-service must clear the bit only on the full-to-not-full step; a design that clears it on any service would unblock the port while a queue is still full. Redundant target sets, and causes that clear while another cause holds the mask, must leave the event counters alone and keep the port stalled; getting this wrong inflates the counts or opens the port early. Stall cycles must go to the cause that cleared last and must equal the exact number of stalled cycles. The bench also checks allocations in both queues in one cycle, which must take consecutive order numbers with the miss first, and bus requests made while retry_wait is high, which must be suppressed.

// File: rtl/cbc_pkg.sv
package cbc_pkg;
    localparam int NCAUSE = 3;

    typedef enum logic [1:0] {
        CZ_MISS = 2'd0,
        CZ_WBUF = 2'd1,
        CZ_TGT  = 2'd2
    } cause_e;

    typedef enum logic {
        ST_OPEN    = 1'b0,
        ST_STALLED = 1'b1
    } blk_state_e;
endpackage

// File: rtl/cbc_queue_ctr.sv
module cbc_queue_ctr #(
    parameter int DEPTH = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic alloc,
    input  logic svc,
    output logic accept,
    output logic full,
    output logic set_req,
    output logic clr_req
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] count_nx;
    logic             release_ok;

    always_comb begin
        full       = (count_q == DEPTH_C);
        accept     = alloc && !full;
        release_ok = svc && (count_q != '0);
        count_nx   = count_q + {{(CNT_W-1){1'b0}}, accept}
                             - {{(CNT_W-1){1'b0}}, release_ok};
        set_req    = accept && (count_nx == DEPTH_C);
        clr_req    = release_ok && full && (count_nx != DEPTH_C);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) count_q <= '0;
        else        count_q <= count_nx;
    end

    // R3: occupancy can never pass the depth
    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= DEPTH_C);

    // R3: a full queue keeps its count when only an allocation arrives
    assert_refuse_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (full && alloc && !svc) |=> full);
endmodule

// File: rtl/cbc_block_fsm.sv
module cbc_block_fsm
    import cbc_pkg::*;
#(
    parameter int STAT_W = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NCAUSE-1:0]        set_in,
    input  logic [NCAUSE-1:0]        clr_in,
    output logic                     blocked,
    output logic [NCAUSE-1:0]        mask,
    output logic [NCAUSE*STAT_W-1:0] evt_flat,
    output logic [NCAUSE*STAT_W-1:0] cyc_flat
);
    localparam int CZ_W = 2;

    blk_state_e        state_q, state_nx;
    logic [NCAUSE-1:0] mask_q, mask_nx;
    logic [STAT_W-1:0] now_q, stamp_q;
    logic              go_start, go_release;
    logic [CZ_W-1:0]   first_cz, last_cz;
    logic [NCAUSE-1:0] dropped;

    logic [STAT_W-1:0] evt_q [NCAUSE];
    logic [STAT_W-1:0] cyc_q [NCAUSE];

    // next mask and state transitions
    always_comb begin
        mask_nx    = (mask_q | set_in) & ~clr_in;
        state_nx   = state_q;
        go_start   = 1'b0;
        go_release = 1'b0;
        unique case (state_q)
            ST_OPEN: begin
                if (mask_nx != '0) begin       // START
                    state_nx = ST_STALLED;
                    go_start = 1'b1;
                end
            end
            ST_STALLED: begin
                if (mask_nx == '0) begin       // RELEASE
                    state_nx   = ST_OPEN;
                    go_release = 1'b1;
                end                            // else HOLD
            end
            default: state_nx = ST_OPEN;
        endcase
    end

    // cause selection: lowest opener, highest closer
    always_comb begin
        dropped  = clr_in & mask_q;
        first_cz = '0;
        for (int c = NCAUSE - 1; c >= 0; c--) begin
            if (mask_nx[c]) first_cz = CZ_W'(c);
        end
        last_cz = '0;
        for (int c = 0; c < NCAUSE; c++) begin
            if (dropped[c]) last_cz = CZ_W'(c);
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_OPEN;
            mask_q  <= '0;
            now_q   <= '0;
            stamp_q <= '0;
        end else begin
            state_q <= state_nx;
            mask_q  <= mask_nx;
            now_q   <= now_q + 1'b1;
            if (go_start) stamp_q <= now_q;
        end
    end

    // per-cause statistics
    for (genvar c = 0; c < NCAUSE; c++) begin : g_stat
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                evt_q[c] <= '0;
                cyc_q[c] <= '0;
            end else begin
                if (go_start && first_cz == CZ_W'(c))
                    evt_q[c] <= evt_q[c] + 1'b1;
                if (go_release && last_cz == CZ_W'(c))
                    cyc_q[c] <= cyc_q[c] + (now_q - stamp_q);
            end
        end
        assign evt_flat[c*STAT_W +: STAT_W] = evt_q[c];
        assign cyc_flat[c*STAT_W +: STAT_W] = cyc_q[c];
    end

    // outputs
    always_comb begin
        blocked = (state_q == ST_STALLED);
        mask    = mask_q;
    end

    logic [STAT_W-1:0] evt_total, cyc_total;
    always_comb begin
        evt_total = '0;
        cyc_total = '0;
        for (int c = 0; c < NCAUSE; c++) begin
            evt_total = evt_total + evt_q[c];
            cyc_total = cyc_total + cyc_q[c];
        end
    end

    // R2: stall state tracks a nonempty mask
    assert_blocked_mask_R2: assert property (@(posedge clk) disable iff (!rst_n)
        blocked == (mask_q != '0));

    // R9: each stall opening counts exactly once
    assert_evt_once_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (blocked && !$past(blocked)) |-> evt_total == $past(evt_total) + 1'b1);

    // R9: no count while the port stays stalled
    assert_evt_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (blocked && $past(blocked)) |-> $stable(evt_total));

    // R10: a release always charges some cycles
    assert_cyc_charge_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!blocked && $past(blocked)) |-> cyc_total != $past(cyc_total));
endmodule

// File: rtl/cbc_alloc_stamp.sv
module cbc_alloc_stamp
    import cbc_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int SIZE_W    = 8,
    parameter int ORD_W     = 16,
    parameter int BLK_BYTES = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ms_acc,
    input  logic              ms_cacheable,
    input  logic [ADDR_W-1:0] ms_addr,
    input  logic [SIZE_W-1:0] ms_size,
    input  logic              ms_bus,
    input  logic              wb_acc,
    input  logic [ADDR_W-1:0] wb_addr,
    input  logic [SIZE_W-1:0] wb_size,
    input  logic              wb_bus,
    input  logic              retry_wait,
    output logic              ms_grant,
    output logic [ADDR_W-1:0] ms_gnt_addr,
    output logic [SIZE_W-1:0] ms_gnt_size,
    output logic [ORD_W-1:0]  ms_gnt_order,
    output logic              wb_grant,
    output logic [ADDR_W-1:0] wb_gnt_addr,
    output logic [SIZE_W-1:0] wb_gnt_size,
    output logic [ORD_W-1:0]  wb_gnt_order,
    output logic              bus_req,
    output logic [1:0]        bus_cause
);
    localparam logic [ADDR_W-1:0] BLK_MASK = ~(ADDR_W'(BLK_BYTES - 1));
    localparam logic [SIZE_W-1:0] BLK_SIZE = SIZE_W'(BLK_BYTES);

    logic [ORD_W-1:0]  ord_q;
    logic [ORD_W-1:0]  wb_ord;
    logic [ADDR_W-1:0] ms_addr_eff;
    logic [SIZE_W-1:0] ms_size_eff;
    logic              ms_wants, wb_wants;

    always_comb begin
        wb_ord      = ord_q + {{(ORD_W-1){1'b0}}, ms_acc};
        ms_addr_eff = ms_cacheable ? (ms_addr & BLK_MASK) : ms_addr;
        ms_size_eff = ms_cacheable ? BLK_SIZE : ms_size;
        ms_wants    = ms_acc && ms_bus;
        wb_wants    = wb_acc && wb_bus;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ord_q        <= '0;
            ms_grant     <= 1'b0;
            wb_grant     <= 1'b0;
            bus_req      <= 1'b0;
            bus_cause    <= CZ_MISS;
            ms_gnt_addr  <= '0;
            ms_gnt_size  <= '0;
            ms_gnt_order <= '0;
            wb_gnt_addr  <= '0;
            wb_gnt_size  <= '0;
            wb_gnt_order <= '0;
        end else begin
            ord_q    <= wb_ord + {{(ORD_W-1){1'b0}}, wb_acc};
            ms_grant <= ms_acc;
            wb_grant <= wb_acc;
            if (ms_acc) begin
                ms_gnt_addr  <= ms_addr_eff;
                ms_gnt_size  <= ms_size_eff;
                ms_gnt_order <= ord_q;
            end
            if (wb_acc) begin
                wb_gnt_addr  <= wb_addr;
                wb_gnt_size  <= wb_size;
                wb_gnt_order <= wb_ord;
            end
            bus_req <= (ms_wants || wb_wants) && !retry_wait;
            if (ms_wants || wb_wants)
                bus_cause <= ms_wants ? CZ_MISS : CZ_WBUF;
        end
    end

    // R6: a same-cycle pair takes consecutive numbers, miss first
    assert_order_pair_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ms_grant && wb_grant) |-> wb_gnt_order == ms_gnt_order + 1'b1);

    // R8: no bus request out of a retry-wait cycle
    assert_bus_retry_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> $past(!retry_wait));

    // R8: cause code stays inside the two queue codes
    assert_bus_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> bus_cause != CZ_TGT);
endmodule

// File: rtl/cache_block_ctrl.sv
module cache_block_ctrl
    import cbc_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int SIZE_W    = 8,
    parameter int ORD_W     = 16,
    parameter int STAT_W    = 32,
    parameter int BLK_BYTES = 64,
    parameter int MS_DEPTH  = 4,
    parameter int WB_DEPTH  = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ms_alloc,
    input  logic                     ms_cacheable,
    input  logic [ADDR_W-1:0]        ms_addr,
    input  logic [SIZE_W-1:0]        ms_size,
    input  logic                     ms_bus,
    input  logic                     ms_svc,
    input  logic                     wb_alloc,
    input  logic [ADDR_W-1:0]        wb_addr,
    input  logic [SIZE_W-1:0]        wb_size,
    input  logic                     wb_bus,
    input  logic                     wb_svc,
    input  logic                     tgt_set,
    input  logic                     tgt_clr,
    input  logic                     retry_wait,
    output logic                     cpu_blocked,
    output logic [NCAUSE-1:0]        block_mask,
    output logic                     ms_full,
    output logic                     wb_full,
    output logic                     ms_grant,
    output logic [ADDR_W-1:0]        ms_gnt_addr,
    output logic [SIZE_W-1:0]        ms_gnt_size,
    output logic [ORD_W-1:0]         ms_gnt_order,
    output logic                     wb_grant,
    output logic [ADDR_W-1:0]        wb_gnt_addr,
    output logic [SIZE_W-1:0]        wb_gnt_size,
    output logic [ORD_W-1:0]         wb_gnt_order,
    output logic                     bus_req,
    output logic [1:0]               bus_cause,
    output logic [NCAUSE*STAT_W-1:0] stall_events,
    output logic [NCAUSE*STAT_W-1:0] stall_cycles
);
    logic              ms_acc, wb_acc;
    logic              ms_set, ms_clr, wb_set, wb_clr;
    logic [NCAUSE-1:0] set_vec, clr_vec;

    cbc_queue_ctr #(.DEPTH(MS_DEPTH)) u_ms_q (
        .clk(clk), .rst_n(rst_n), .alloc(ms_alloc), .svc(ms_svc),
        .accept(ms_acc), .full(ms_full), .set_req(ms_set), .clr_req(ms_clr)
    );

    cbc_queue_ctr #(.DEPTH(WB_DEPTH)) u_wb_q (
        .clk(clk), .rst_n(rst_n), .alloc(wb_alloc), .svc(wb_svc),
        .accept(wb_acc), .full(wb_full), .set_req(wb_set), .clr_req(wb_clr)
    );

    always_comb begin
        set_vec = '0;
        clr_vec = '0;
        set_vec[CZ_MISS] = ms_set;
        clr_vec[CZ_MISS] = ms_clr;
        set_vec[CZ_WBUF] = wb_set;
        clr_vec[CZ_WBUF] = wb_clr;
        set_vec[CZ_TGT]  = tgt_set && !tgt_clr;
        clr_vec[CZ_TGT]  = tgt_clr && !tgt_set;
    end

    cbc_block_fsm #(.STAT_W(STAT_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .set_in(set_vec), .clr_in(clr_vec),
        .blocked(cpu_blocked), .mask(block_mask),
        .evt_flat(stall_events), .cyc_flat(stall_cycles)
    );

    cbc_alloc_stamp #(
        .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .ORD_W(ORD_W), .BLK_BYTES(BLK_BYTES)
    ) u_stamp (
        .clk(clk), .rst_n(rst_n),
        .ms_acc(ms_acc), .ms_cacheable(ms_cacheable), .ms_addr(ms_addr),
        .ms_size(ms_size), .ms_bus(ms_bus),
        .wb_acc(wb_acc), .wb_addr(wb_addr), .wb_size(wb_size), .wb_bus(wb_bus),
        .retry_wait(retry_wait),
        .ms_grant(ms_grant), .ms_gnt_addr(ms_gnt_addr), .ms_gnt_size(ms_gnt_size),
        .ms_gnt_order(ms_gnt_order),
        .wb_grant(wb_grant), .wb_gnt_addr(wb_gnt_addr), .wb_gnt_size(wb_gnt_size),
        .wb_gnt_order(wb_gnt_order),
        .bus_req(bus_req), .bus_cause(bus_cause)
    );

    // R3: a full miss queue always shows in mask bit 0
    assert_ms_full_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ms_full == block_mask[CZ_MISS]);

    // R3: a full write buffer always shows in mask bit 1
    assert_wb_full_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wb_full == block_mask[CZ_WBUF]);

    // R3: no grant follows an allocation into a full queue
    assert_no_grant_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ms_alloc && ms_full) |=> !ms_grant);
endmodule

// File: tb/cache_block_ctrl_tb.sv
module cache_block_ctrl_tb;
    localparam int AW = 32, SW = 8, OW = 16, TW = 32, BLK = 64, MSD = 4, WBD = 3;

    logic clk = 1'b0, rst_n = 1'b0;
    logic ms_alloc = 0, ms_cacheable = 0, ms_bus = 0, ms_svc = 0;
    logic wb_alloc = 0, wb_bus = 0, wb_svc = 0;
    logic tgt_set = 0, tgt_clr = 0, retry_wait = 0;
    logic [AW-1:0] ms_addr = '0, wb_addr = '0;
    logic [SW-1:0] ms_size = '0, wb_size = '0;

    logic cpu_blocked, ms_full, wb_full, ms_grant, wb_grant, bus_req;
    logic [2:0] block_mask;
    logic [AW-1:0] ms_gnt_addr, wb_gnt_addr;
    logic [SW-1:0] ms_gnt_size, wb_gnt_size;
    logic [OW-1:0] ms_gnt_order, wb_gnt_order;
    logic [1:0] bus_cause;
    logic [3*TW-1:0] stall_events, stall_cycles;

    cache_block_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .ms_alloc(ms_alloc), .ms_cacheable(ms_cacheable),
        .ms_addr(ms_addr), .ms_size(ms_size), .ms_bus(ms_bus), .ms_svc(ms_svc),
        .wb_alloc(wb_alloc), .wb_addr(wb_addr), .wb_size(wb_size), .wb_bus(wb_bus),
        .wb_svc(wb_svc), .tgt_set(tgt_set), .tgt_clr(tgt_clr), .retry_wait(retry_wait),
        .cpu_blocked(cpu_blocked), .block_mask(block_mask), .ms_full(ms_full),
        .wb_full(wb_full), .ms_grant(ms_grant), .ms_gnt_addr(ms_gnt_addr),
        .ms_gnt_size(ms_gnt_size), .ms_gnt_order(ms_gnt_order), .wb_grant(wb_grant),
        .wb_gnt_addr(wb_gnt_addr), .wb_gnt_size(wb_gnt_size), .wb_gnt_order(wb_gnt_order),
        .bus_req(bus_req), .bus_cause(bus_cause),
        .stall_events(stall_events), .stall_cycles(stall_cycles)
    );

    always #10 clk = ~clk;  // 50 MHz

    int total = 0, bad = 0;
    bit finished = 0;

    // reference model state
    int m_ms_cnt, m_wb_cnt;
    logic [2:0] m_mask;
    logic [OW-1:0] m_ord;
    logic [TW-1:0] m_now, m_cap;
    logic [TW-1:0] m_evt [3];
    logic [TW-1:0] m_cyc [3];
    // expected outputs
    logic e_ms_grant, e_wb_grant, e_bus;
    logic [1:0] e_cause;
    logic [AW-1:0] e_ms_addr, e_wb_addr;
    logic [SW-1:0] e_ms_size, e_wb_size;
    logic [OW-1:0] e_ms_ord, e_wb_ord;

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_ms_cnt = 0; m_wb_cnt = 0; m_mask = '0; m_ord = '0;
        m_now = '0; m_cap = '0;
        for (int c = 0; c < 3; c++) begin m_evt[c] = '0; m_cyc[c] = '0; end
    endtask

    function automatic logic [AW-1:0] align_blk(input logic [AW-1:0] a);
        return a & ~(AW'(BLK - 1));
    endfunction

    task automatic model_step();
        logic ms_acc, wb_acc, ms_rel, wb_rel;
        int ms_n, wb_n;
        logic [2:0] st, cl, nx, drop;
        ms_acc = ms_alloc && (m_ms_cnt != MSD);
        wb_acc = wb_alloc && (m_wb_cnt != WBD);
        ms_rel = ms_svc && (m_ms_cnt != 0);
        wb_rel = wb_svc && (m_wb_cnt != 0);
        ms_n = m_ms_cnt + int'(ms_acc) - int'(ms_rel);
        wb_n = m_wb_cnt + int'(wb_acc) - int'(wb_rel);
        st = {tgt_set && !tgt_clr, wb_acc && wb_n == WBD, ms_acc && ms_n == MSD};
        cl = {tgt_clr && !tgt_set, wb_rel && m_wb_cnt == WBD && wb_n != WBD,
              ms_rel && m_ms_cnt == MSD && ms_n != MSD};
        nx = (m_mask | st) & ~cl;
        drop = cl & m_mask;
        if (m_mask == 0 && nx != 0) begin
            for (int c = 2; c >= 0; c--) if (nx[c]) begin
                if (c == 0 || !nx[0] && (c == 1 || !nx[1])) m_evt[c] = m_evt[c] + 1;
            end
            m_cap = m_now;
        end
        if (m_mask != 0 && nx == 0) begin
            for (int c = 2; c >= 0; c--) if (drop[c]) begin
                if (c == 2 || !drop[2] && (c == 1 || !drop[1])) m_cyc[c] = m_cyc[c] + (m_now - m_cap);
            end
        end
        e_ms_grant = ms_acc; e_wb_grant = wb_acc;
        e_ms_addr = ms_cacheable ? align_blk(ms_addr) : ms_addr;
        e_ms_size = ms_cacheable ? SW'(BLK) : ms_size;
        e_wb_addr = wb_addr; e_wb_size = wb_size;
        e_ms_ord = m_ord;
        e_wb_ord = m_ord + OW'(ms_acc);
        m_ord = m_ord + OW'(ms_acc) + OW'(wb_acc);
        e_bus = ((ms_acc && ms_bus) || (wb_acc && wb_bus)) && !retry_wait;
        e_cause = (ms_acc && ms_bus) ? 2'd0 : 2'd1;
        m_ms_cnt = ms_n; m_wb_cnt = wb_n; m_mask = nx;
        m_now = m_now + 1;
    endtask

    task automatic compare_all();
        chk("R2", "mask", 64'(block_mask), 64'(m_mask));
        chk("R2", "blocked", 64'(cpu_blocked), 64'(m_mask != 0));
        chk("R3", "ms_full", 64'(ms_full), 64'(m_ms_cnt == MSD));
        chk("R3", "wb_full", 64'(wb_full), 64'(m_wb_cnt == WBD));
        chk("R3", "ms_grant", 64'(ms_grant), 64'(e_ms_grant));
        chk("R3", "wb_grant", 64'(wb_grant), 64'(e_wb_grant));
        if (e_ms_grant) begin
            chk("R6", "ms_order", 64'(ms_gnt_order), 64'(e_ms_ord));
            chk("R7", "ms_addr", 64'(ms_gnt_addr), 64'(e_ms_addr));
            chk("R7", "ms_size", 64'(ms_gnt_size), 64'(e_ms_size));
        end
        if (e_wb_grant) begin
            chk("R6", "wb_order", 64'(wb_gnt_order), 64'(e_wb_ord));
            chk("R7", "wb_addr", 64'(wb_gnt_addr), 64'(e_wb_addr));
            chk("R7", "wb_size", 64'(wb_gnt_size), 64'(e_wb_size));
        end
        chk("R8", "bus_req", 64'(bus_req), 64'(e_bus));
        if (e_bus) chk("R8", "bus_cause", 64'(bus_cause), 64'(e_cause));
        for (int c = 0; c < 3; c++) begin
            chk("R9", "events", 64'(stall_events[c*TW +: TW]), 64'(m_evt[c]));
            chk("R10", "cycles", 64'(stall_cycles[c*TW +: TW]), 64'(m_cyc[c]));
        end
    endtask

    task automatic step();
        model_step();
        @(posedge clk);
        #1;
        compare_all();
    endtask

    task automatic idle_in();
        ms_alloc = 0; ms_svc = 0; wb_alloc = 0; wb_svc = 0;
        tgt_set = 0; tgt_clr = 0; ms_bus = 0; wb_bus = 0; retry_wait = 0;
    endtask

    initial begin
        #(200000 * 20);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        rst_n = 0;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1;
        // R1: reset state
        chk("R1", "blocked", 64'(cpu_blocked), 64'd0);
        chk("R1", "mask", 64'(block_mask), 64'd0);
        chk("R1", "events", 64'(stall_events), 64'd0);
        chk("R1", "cycles", 64'(stall_cycles), 64'd0);

        // fill the miss queue with cacheable misses (R3, R7, R1 order 0)
        ms_alloc = 1; ms_cacheable = 1; ms_addr = 32'h1234_5678; ms_size = 8'd4; ms_bus = 1;
        step();
        chk("R1", "first order", 64'(ms_gnt_order), 64'd0);
        chk("R7", "aligned", 64'(ms_gnt_addr), 64'h1234_5640);
        step(); step(); step();
        chk("R9", "ms open evt", 64'(stall_events[0 +: TW]), 64'd1);
        // alloc while full refused, target cause joins (R3, R5)
        ms_bus = 0; tgt_set = 1;
        step();
        chk("R3", "refused grant", 64'(ms_grant), 64'd0);
        chk("R9", "no evt while stalled", 64'(stall_events), {32'd0, 32'd0, 32'd1});
        ms_alloc = 0;
        step();  // redundant target set
        chk("R5", "redundant set", 64'(stall_events), {32'd0, 32'd0, 32'd1});
        tgt_set = 0; ms_svc = 1;
        step();
        chk("R4", "ms bit cleared", 64'(block_mask), 64'b100);
        step();  // not full before: no change
        chk("R4", "still blocked", 64'(cpu_blocked), 64'd1);
        ms_svc = 0; tgt_set = 1; tgt_clr = 1;
        step();
        chk("R5", "both ignored", 64'(block_mask), 64'b100);
        tgt_set = 0;
        step();
        chk("R10", "charged to tgt", 64'(stall_cycles[2*TW +: TW]), 64'd6);
        chk("R2", "released", 64'(cpu_blocked), 64'd0);
        tgt_clr = 0; ms_svc = 1;
        step(); step(); step();
        // simultaneous allocations (R6, R8)
        idle_in(); ms_alloc = 1; ms_cacheable = 0; ms_addr = 32'h0000_0ABC; ms_size = 8'd8;
        wb_alloc = 1; wb_addr = 32'h0000_0F01; wb_size = 8'd2; ms_bus = 1; wb_bus = 1;
        step();
        chk("R8", "miss wins", 64'(bus_cause), 64'd0);
        retry_wait = 1; ms_alloc = 0;
        step();
        chk("R8", "suppressed", 64'(bus_req), 64'd0);
        idle_in(); wb_svc = 1;
        step(); step();
        idle_in();
        step();

        // constrained random
        for (int i = 0; i < 4000; i++) begin
            int fill;
            fill = ((i / 150) % 2 == 0) ? 60 : 20;
            ms_alloc = ($urandom % 100) < fill;
            wb_alloc = ($urandom % 100) < fill;
            ms_svc = ($urandom % 100) < (80 - fill);
            wb_svc = ($urandom % 100) < (80 - fill);
            ms_cacheable = $urandom % 2;
            ms_addr = $urandom; wb_addr = $urandom;
            ms_size = SW'($urandom); wb_size = SW'($urandom);
            ms_bus = $urandom % 2; wb_bus = $urandom % 2;
            tgt_set = ($urandom % 100) < 5;
            tgt_clr = ($urandom % 100) < 8;
            retry_wait = ($urandom % 100) < 25;
            step();
        end
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule